// File: doc/BRIEF.md
# Clock Gear Frequency Ramp Controller

This block raises or lowers the effective clock rate of a downstream domain gradually, so that the supply current drawn by that logic never changes by a large amount in one step. It runs on a fast input clock and produces a clock-enable that passes some of the input cycles. Time is cut into frames of 64 input cycles. Within each frame the current gear step, from STEP0 to STEP63, sets how many of those cycles are passed. The passed cycles are spread evenly across the frame by an accumulator.

A one-cycle start pulse, together with a direction bit, begins a ramp toward full rate (gear-up) or toward the slowest rate (gear-down). The start step, the number of frames spent at each step and the step increment are captured when the start pulse is taken. Step changes happen only on frame boundaries. The block reports busy during a ramp and pulses done when the ramp has reached its end step.

Top module: `gear_ramp_ctrl`

## Requirements
- R1: A synchronous reset leaves the block idle with step_o = 63, clk_en_o high, busy_o low and done_o low.
- R2: A frame is 64 input cycles long. step_o changes only in the first cycle of a frame, at position 0 of the free-running 64-cycle frame count that starts at 0 after reset.
- R3: At step k, clk_en_o is high on exactly k+1 of the 64 cycles of a frame. At frame position c (0..63) it is high when floor((c+1)(k+1)/64) > floor(c(k+1)/64), so step 63 enables every cycle.
- R4: A start pulse taken while busy_o is low raises busy_o in the next cycle. A start pulse taken while busy_o is high has no effect. A start taken in the last cycle of a frame waits for the next frame's end before loading.
- R5: At the first frame end after the start was taken, step_o loads the start step. A start_step_i of 0 or 1 gives step 0, a value n in 2..63 gives n-1, and a value above 63 gives 62.
- R6: Each step, the loaded start step included, is held for hold_frames_i+1 frames.
- R7: After its hold, the step moves by step_width_i+1, up when dir_up_i was 1 and down when it was 0. It saturates at 63 going up and at 0 going down.
- R8: When a move lands on the end step (63 up, 0 down), busy_o falls and done_o is high for exactly one cycle, both in the first cycle of the new frame.
- R9: Changes to dir_up_i, start_step_i, hold_frames_i and step_width_i while busy_o is high do not change the ramp in progress.
- R10: A start pulse given in the cycle where done_o is high is accepted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast input clock |
| rst | input | 1 | Synchronous reset, active high |
| start_i | input | 1 | One-cycle pulse that begins a ramp |
| dir_up_i | input | 1 | Ramp direction: 1 toward step 63, 0 toward step 0 |
| start_step_i | input | 7 | Start step setting (1 selects step 0) |
| hold_frames_i | input | 8 | Frames per step, minus one |
| step_width_i | input | 2 | Step increment, minus one |
| clk_en_o | output | 1 | Clock enable for the downstream domain |
| step_o | output | 6 | Current gear step |
| busy_o | output | 1 | Ramp in progress |
| done_o | output | 1 | One-cycle pulse at ramp completion |

## Verification
Two events can fall in the same cycle. A start pulse can arrive in the last cycle of a frame, just as a frame boundary is being processed. A new start can also arrive in the very cycle that done is high. The bench provokes the first by timing the start from its own frame count so that it lands in position 63. It then checks that the step is not loaded at that boundary but one full frame later. It provokes the second by pulsing start as soon as it sees done, and checks that busy returns one cycle later. Its cycle-by-cycle reference model of enable, step, busy and done judges both cases on every clock.

// File: rtl/gear_pkg.sv
package gear_pkg;
    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_PEND = 2'd1,
        PH_RAMP = 2'd2
    } phase_e;
endpackage

// File: rtl/gear_frame_timer.sv
module gear_frame_timer #(
    parameter int POS_W = 6
) (
    input  logic             clk,
    input  logic             rst,
    output logic [POS_W-1:0] pos_o,
    output logic             last_o
);
    typedef struct packed {
        logic [POS_W-1:0] pos;
    } tmr_s;

    tmr_s tmr_d, tmr_q;

    always_comb begin
        tmr_d     = tmr_q;
        tmr_d.pos = tmr_q.pos + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) tmr_q <= '0;
        else     tmr_q <= tmr_d;
    end

    assign pos_o  = tmr_q.pos;
    assign last_o = &tmr_q.pos;
endmodule

// File: rtl/gear_pulse_spreader.sv
module gear_pulse_spreader #(
    parameter int POS_W = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [POS_W-1:0] step_i,
    output logic             en_o
);
    localparam int SUM_W = POS_W + 1;

    typedef struct packed {
        logic [POS_W-1:0] acc;
    } spr_s;

    spr_s             spr_d, spr_q;
    logic [SUM_W-1:0] sum;

    always_comb begin
        sum       = SUM_W'(spr_q.acc) + SUM_W'(step_i) + SUM_W'(1);
        spr_d     = spr_q;
        spr_d.acc = sum[POS_W-1:0];
    end

    always_ff @(posedge clk) begin
        if (rst) spr_q <= '0;
        else     spr_q <= spr_d;
    end

    assign en_o = sum[POS_W];
endmodule

// File: rtl/gear_step_sequencer.sv
module gear_step_sequencer
    import gear_pkg::*;
#(
    parameter int POS_W  = 6,
    parameter int SSN_W  = 7,
    parameter int LOOP_W = 8,
    parameter int WID_W  = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              frame_last_i,
    input  logic              start_i,
    input  logic              dir_up_i,
    input  logic [SSN_W-1:0]  start_step_i,
    input  logic [LOOP_W-1:0] hold_i,
    input  logic [WID_W-1:0]  width_i,
    output logic [POS_W-1:0]  step_o,
    output logic              busy_o,
    output logic              done_o
);
    localparam int MW = POS_W + 1;
    localparam logic [POS_W-1:0] TOP_S  = '1;
    localparam logic [MW-1:0]    TOP_M  = MW'(TOP_S);
    localparam logic [SSN_W-1:0] TOP_SN = SSN_W'(TOP_S);

    typedef struct packed {
        phase_e            phase;
        logic              up;
        logic [POS_W-1:0]  first;
        logic [LOOP_W-1:0] hold;
        logic [LOOP_W-1:0] left;
        logic [WID_W-1:0]  wid;
        logic [POS_W-1:0]  step;
        logic              done;
    } seq_s;

    seq_s             seq_d, seq_q;
    logic [SSN_W-1:0] ssn_c;
    logic [POS_W-1:0] first_map;
    logic [MW-1:0]    inc, up_sum;
    logic [POS_W-1:0] nxt_up, nxt_dn, nxt, end_step;

    always_comb begin
        ssn_c     = (start_step_i > TOP_SN) ? TOP_SN : start_step_i;
        first_map = (ssn_c == '0) ? '0 : POS_W'(ssn_c - SSN_W'(1));

        inc      = MW'(seq_q.wid) + MW'(1);
        up_sum   = MW'(seq_q.step) + inc;
        nxt_up   = (up_sum > TOP_M) ? TOP_S : up_sum[POS_W-1:0];
        nxt_dn   = (MW'(seq_q.step) < inc) ? '0 : POS_W'(MW'(seq_q.step) - inc);
        nxt      = seq_q.up ? nxt_up : nxt_dn;
        end_step = seq_q.up ? TOP_S : '0;

        seq_d      = seq_q;
        seq_d.done = 1'b0;
        unique case (seq_q.phase)
            PH_IDLE: begin
                if (start_i) begin
                    seq_d.phase = PH_PEND;
                    seq_d.up    = dir_up_i;
                    seq_d.first = first_map;
                    seq_d.hold  = hold_i;
                    seq_d.wid   = width_i;
                end
            end
            PH_PEND: begin
                if (frame_last_i) begin
                    seq_d.phase = PH_RAMP;
                    seq_d.step  = seq_q.first;
                    seq_d.left  = seq_q.hold;
                end
            end
            PH_RAMP: begin
                if (frame_last_i) begin
                    if (seq_q.left == '0) begin
                        seq_d.step = nxt;
                        seq_d.left = seq_q.hold;
                        if (nxt == end_step) begin
                            seq_d.phase = PH_IDLE;
                            seq_d.done  = 1'b1;
                        end
                    end else begin
                        seq_d.left = seq_q.left - 1'b1;
                    end
                end
            end
            default: seq_d.phase = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            seq_q       <= '0;
            seq_q.phase <= PH_IDLE;
            seq_q.step  <= TOP_S;
        end else begin
            seq_q <= seq_d;
        end
    end

    assign step_o = seq_q.step;
    assign busy_o = (seq_q.phase != PH_IDLE);
    assign done_o = seq_q.done;
endmodule

// File: rtl/gear_ramp_ctrl.sv
module gear_ramp_ctrl #(
    parameter int POS_W  = 6,
    parameter int SSN_W  = 7,
    parameter int LOOP_W = 8,
    parameter int WID_W  = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  logic              dir_up_i,
    input  logic [SSN_W-1:0]  start_step_i,
    input  logic [LOOP_W-1:0] hold_frames_i,
    input  logic [WID_W-1:0]  step_width_i,
    output logic              clk_en_o,
    output logic [POS_W-1:0]  step_o,
    output logic              busy_o,
    output logic              done_o
);
    logic [POS_W-1:0] frame_pos;
    logic             frame_last;

    gear_frame_timer #(.POS_W(POS_W)) u_timer (
        .clk    (clk),
        .rst    (rst),
        .pos_o  (frame_pos),
        .last_o (frame_last)
    );

    gear_step_sequencer #(
        .POS_W  (POS_W),
        .SSN_W  (SSN_W),
        .LOOP_W (LOOP_W),
        .WID_W  (WID_W)
    ) u_seq (
        .clk          (clk),
        .rst          (rst),
        .frame_last_i (frame_last),
        .start_i      (start_i),
        .dir_up_i     (dir_up_i),
        .start_step_i (start_step_i),
        .hold_i       (hold_frames_i),
        .width_i      (step_width_i),
        .step_o       (step_o),
        .busy_o       (busy_o),
        .done_o       (done_o)
    );

    gear_pulse_spreader #(.POS_W(POS_W)) u_spread (
        .clk    (clk),
        .rst    (rst),
        .step_i (step_o),
        .en_o   (clk_en_o)
    );
endmodule

// File: rtl/gear_ramp_chk.sv
module gear_ramp_chk #(
    parameter int POS_W = 6
) (
    input logic             clk,
    input logic             rst,
    input logic             start_i,
    input logic             clk_en_o,
    input logic [POS_W-1:0] step_o,
    input logic             busy_o,
    input logic             done_o,
    input logic [POS_W-1:0] frame_pos
);
    localparam logic [POS_W-1:0] TOP_S = '1;

    // R8
    done_single_chk: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);

    // R8
    done_idle_chk: assert property (@(posedge clk) disable iff (rst)
        done_o |-> !busy_o);

    // R2
    step_on_boundary_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(step_o) |-> (frame_pos == '0));

    // R3
    full_rate_chk: assert property (@(posedge clk) disable iff (rst)
        (step_o == TOP_S) |-> clk_en_o);

    // R4
    busy_cause_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(busy_o) |-> $past(start_i));
endmodule

bind gear_ramp_ctrl gear_ramp_chk #(.POS_W(POS_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .start_i   (start_i),
    .clk_en_o  (clk_en_o),
    .step_o    (step_o),
    .busy_o    (busy_o),
    .done_o    (done_o),
    .frame_pos (frame_pos)
);

// File: tb/tb_gear_ramp_ctrl.sv
module tb_gear_ramp_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 150000;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       start_i = 1'b0;
    logic       dir_up_i = 1'b0;
    logic [6:0] start_step_i = '0;
    logic [7:0] hold_frames_i = '0;
    logic [1:0] step_width_i = '0;
    logic       clk_en_o;
    logic [5:0] step_o;
    logic       busy_o;
    logic       done_o;

    int nchk = 0;
    int nfail = 0;
    bit finished = 1'b0;

    // reference model state
    int  m_cnt, m_step, m_left, m_ss, m_loop, m_wid;
    bit  m_busy, m_pend, m_done, m_up;

    always #(CLK_PERIOD/2) clk = ~clk;

    gear_ramp_ctrl dut (
        .clk           (clk),
        .rst           (rst),
        .start_i       (start_i),
        .dir_up_i      (dir_up_i),
        .start_step_i  (start_step_i),
        .hold_frames_i (hold_frames_i),
        .step_width_i  (step_width_i),
        .clk_en_o      (clk_en_o),
        .step_o        (step_o),
        .busy_o        (busy_o),
        .done_o        (done_o)
    );

    function automatic int map_start(int v);
        if (v > 63) v = 63;
        if (v < 1) v = 1;
        return v - 1;
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_cnt = 0; m_step = 63; m_busy = 0; m_pend = 0; m_done = 0;
            m_left = 0; m_up = 0; m_ss = 0; m_loop = 0; m_wid = 0;
        end else begin
            m_done = 0;
            if (!m_busy && start_i) begin
                m_busy = 1; m_pend = 1; m_up = dir_up_i;
                m_ss = map_start(int'(start_step_i));
                m_loop = int'(hold_frames_i); m_wid = int'(step_width_i) + 1;
            end else if (m_busy && m_cnt == 63) begin
                if (m_pend) begin
                    m_pend = 0; m_step = m_ss; m_left = m_loop;
                end else if (m_left == 0) begin
                    if (m_up) m_step = (m_step + m_wid > 63) ? 63 : m_step + m_wid;
                    else      m_step = (m_step - m_wid < 0) ? 0 : m_step - m_wid;
                    m_left = m_loop;
                    if (m_step == (m_up ? 63 : 0)) begin
                        m_busy = 0; m_done = 1;
                    end
                end else begin
                    m_left = m_left - 1;
                end
            end
            m_cnt = (m_cnt + 1) % 64;
        end
    end

    task automatic check(bit ok, string req, int act, int exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // per-cycle comparison against the reference model
    always @(negedge clk) begin
        if (!rst && !finished) begin
            int  k;
            bit  exp_en;
            k = m_step + 1;
            exp_en = (((m_cnt + 1) * k) / 64) > ((m_cnt * k) / 64);
            check(clk_en_o == exp_en, "R3 clk_en", int'(clk_en_o), int'(exp_en));
            check(int'(step_o) == m_step, "R5 R6 R7 step", int'(step_o), m_step);
            check(busy_o == m_busy, "R4 busy", int'(busy_o), int'(m_busy));
            check(done_o == m_done, "R8 done", int'(done_o), int'(m_done));
        end
    end

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
            $finish;
        end
    endtask

    task automatic launch(bit up, int ssn, int hold, int wid);
        @(negedge clk); #1;
        start_i = 1'b1; dir_up_i = up;
        start_step_i = 7'(ssn); hold_frames_i = 8'(hold); step_width_i = 2'(wid);
        @(negedge clk); #1;
        start_i = 1'b0;
    endtask

    task automatic wait_done();
        for (int i = 0; i < 40000 && !done_o; i++) @(negedge clk);
        check(done_o == 1'b1, "R8 done reached", int'(done_o), 1);
    endtask

    task automatic count_frame(string req, int exp);
        int n = 0;
        for (int i = 0; i < 64; i++) begin
            @(negedge clk);
            if (clk_en_o) n++;
        end
        check(n == exp, req, n, exp);
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        nchk++; nfail++;
        $display("FAIL watchdog: actual %0d expected %0d", WATCHDOG, 0);
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check(step_o == 6'd63, "R1 step", int'(step_o), 63);
        check(clk_en_o == 1'b1, "R1 clk_en", int'(clk_en_o), 1);
        check(busy_o == 1'b0, "R1 busy", int'(busy_o), 0);
        check(done_o == 1'b0, "R1 done", int'(done_o), 0);
        count_frame("R3 count at step 63", 64);

        // gear-down, start setting 10 -> step 9, width 4
        launch(1'b0, 10, 0, 3);
        check(busy_o == 1'b1, "R4 busy after start", int'(busy_o), 1);
        wait_done();
        check(step_o == 6'd0, "R7 down saturates", int'(step_o), 0);
        count_frame("R3 count at step 0", 1);

        // gear-up from setting 0 (step 0), 2 frames per step, width 1
        launch(1'b1, 0, 1, 0);
        repeat (300) @(negedge clk);
        // R9 config changes and a second start while busy are ignored
        #1;
        dir_up_i = 1'b0; start_step_i = 7'd50; hold_frames_i = 8'd9; step_width_i = 2'd3;
        start_i = 1'b1;
        @(negedge clk); #1 start_i = 1'b0;
        check(busy_o == 1'b1, "R9 still busy", int'(busy_o), 1);
        check(int'(step_o) == m_step, "R9 step unchanged", int'(step_o), m_step);
        wait_done();
        check(step_o == 6'd63, "R7 up saturates", int'(step_o), 63);

        // R10 start in the cycle where done is high
        #1;
        start_i = 1'b1; dir_up_i = 1'b0; start_step_i = 7'd100;
        hold_frames_i = 8'd2; step_width_i = 2'd1;
        @(negedge clk); #1 start_i = 1'b0;
        check(busy_o == 1'b1, "R10 start at done accepted", int'(busy_o), 1);
        while (m_pend) @(negedge clk);
        check(step_o == 6'd62, "R5 start above 63 maps to 62", int'(step_o), 62);
        wait_done();

        // R4 start taken in the last cycle of a frame
        launch(1'b1, 30, 0, 2);
        while (m_cnt != 63 || busy_o) @(negedge clk);
        if (busy_o) wait_done();
        while (m_cnt != 63) @(negedge clk);
        #1 start_i = 1'b1; dir_up_i = 1'b1; start_step_i = 7'd5;
        hold_frames_i = 8'd0; step_width_i = 2'd0;
        @(negedge clk); #1 start_i = 1'b0;
        repeat (63) @(negedge clk);
        check(step_o == 6'd63, "R4 R2 no load at the boundary of acceptance",
              int'(step_o), 63);
        @(negedge clk);
        check(step_o == 6'd4, "R5 R2 load one frame later", int'(step_o), 4);
        wait_done();
        repeat (5) @(negedge clk);
        finish_run();
    end
endmodule